// File: doc/BRIEF.md
# ECC Error Status and Capture Unit

This block sits beside a memory controller's ECC decoder and its address-range checker. It turns their one-cycle event pulses into sticky status that software can read. There are three event classes: correctable ECC errors, uncorrectable ECC errors and accesses outside the configured memory range. Each class has two sticky bits. One bit records that the class has been seen once, and the other records that it happened again. A separate bit records that memory initialization has finished.

For the first event of each class, the block keeps the 64-bit address. For the two ECC classes it also keeps the 64-bit data word. Each class has its own capture set. Later events of a class do not overwrite that capture until software acknowledges the event. The syndrome of the most recent ECC error is always kept. Software reads and writes 32-bit words through a plain register port. It clears status by writing ones. An interrupt line is raised whenever a status bit is set and its enable bit is also set.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every status bit, the syndrome, all capture words and the enable word read as zero, and `irq` is low.
- R2: The first event of a class sets that class's single bit: bit 0 for out-of-range, bit 2 for correctable, bit 4 for uncorrectable. It also captures the event address, and for the ECC classes the event data, into that class's own register set. The new values are readable in the cycle after the pulse.
- R3: An event of a class whose single bit is already set sets the class's repeat bit: bit 1 for out-of-range, bit 3 for correctable, bit 5 for uncorrectable. The captured address and data stay unchanged.
- R4: An `init_evt` pulse sets status bit 6.
- R5: Every correctable or uncorrectable pulse, first or repeated, loads `evt_syn` into bits 23:16 of the status word. Out-of-range events leave the syndrome unchanged.
- R6: Writing the status word (offset 0) clears each status bit 6:0 whose write bit is one. Bits written as zero are kept. Capture words and the syndrome are not changed by this write.
- R7: When an event and an acknowledge of its class land in the same cycle, the event wins. If the single bit was clear, it is set and the event is captured. If the single bit was set, it stays set, the repeat bit is set, and the capture is kept.
- R8: `irq` is high exactly when some status bit 6:0 is set and the matching bit of the enable word (offset 1) is set. It follows register changes without extra delay.
- R9: The register map uses these word offsets:
  - 0: status.
  - 1: enable, bits 6:0 writable; upper bits read zero.
  - 2 and 3: out-of-range address, low word then high word.
  - 4 and 5: correctable address, low then high.
  - 6 and 7: correctable data, low then high.
  - 8 and 9: uncorrectable address, low then high.
  - 10 and 11: uncorrectable data, low then high.

  Writes to offsets 2 to 11 are ignored, and unmapped offsets read zero.
- R10: Correctable and uncorrectable pulses in the same cycle are both recorded, each in its own bits and capture set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oor_evt | input | 1 | Out-of-range access pulse |
| ce_evt | input | 1 | Correctable ECC error pulse |
| ue_evt | input | 1 | Uncorrectable ECC error pulse |
| init_evt | input | 1 | Memory initialization done pulse |
| evt_addr | input | ADDR_W (64) | Address of the event |
| evt_data | input | DATA_W (64) | Data word of the event |
| evt_syn | input | SYN_W (8) | Syndrome of the ECC event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W (4) | Register word offset |
| reg_wdata | input | REG_W (32) | Register write data |
| reg_rdata | output | REG_W (32) | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The capture logic is tried with the following event patterns:
- A lone first event of each class, which tells correct routing into the three capture sets apart from crossed wiring.
- A repeat of the same class, which shows the difference between setting the repeat bit and overwriting the first capture.
- Simultaneous correctable and uncorrectable pulses.
- Out-of-range events that carry a syndrome, which show whether only ECC events update the syndrome.

Acknowledge patterns cover a partial clear and a clear of every bit. They also cover an acknowledge colliding with an event, both when the class was already flagged and when it was clear. This separates event priority from acknowledge priority. The interrupt is sampled under enable words that select a set bit, select only cleared bits, or select nothing.

// File: rtl/ecc_cap_pkg.sv
`timescale 1ns/1ps
package ecc_cap_pkg;
   // status word layout
   localparam int NUM_STAT   = 7;
   localparam int ST_INIT    = 6;
   localparam int SYN_LSB    = 16;

   // event classes; status bits of class c are 2c (single) and 2c+1 (repeat)
   localparam int NUM_CLS    = 3;
   localparam int CLS_OOR    = 0;
   localparam int CLS_CE     = 1;
   localparam int CLS_UE     = 2;

   // register word offsets
   localparam int OFS_STATUS = 0;
   localparam int OFS_ENABLE = 1;
   localparam int OFS_OOR_AL = 2;
   localparam int OFS_OOR_AH = 3;
   localparam int OFS_CE_AL  = 4;
   localparam int OFS_CE_AH  = 5;
   localparam int OFS_CE_DL  = 6;
   localparam int OFS_CE_DH  = 7;
   localparam int OFS_UE_AL  = 8;
   localparam int OFS_UE_AH  = 9;
   localparam int OFS_UE_DL  = 10;
   localparam int OFS_UE_DH  = 11;
   localparam int NUM_OFS    = 12;
endpackage

// File: rtl/ecc_evt_tracker.sv
`timescale 1ns/1ps
module ecc_evt_tracker #(
   parameter int ADDR_W   = 64,
   parameter int DATA_W   = 64,
   parameter bit CAP_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev,
   input  logic              ack_one,
   input  logic              ack_many,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DATA_W-1:0] ev_data,
   output logic              hit_one,
   output logic              hit_many,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data
);
   logic first_hit;
   assign first_hit = ev & ~hit_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_one  <= 1'b0;
         hit_many <= 1'b0;
         cap_addr <= '0;
      end else begin
         hit_one  <= ev | (hit_one & ~ack_one);
         hit_many <= (ev & hit_one) | (hit_many & ~ack_many);
         if (first_hit) cap_addr <= ev_addr;
      end
   end

   generate
      if (CAP_DATA) begin : g_data
         always_ff @(posedge clk) begin
            if (!rst_n)         cap_data <= '0;
            else if (first_hit) cap_data <= ev_data;
         end
      end else begin : g_nodata
         logic unused_data;
         assign unused_data = ^ev_data;
         assign cap_data    = '0;
      end
   endgenerate

   // R2: a first event always leaves the single flag set
   a_r2_first_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && !hit_one) |=> hit_one);
   // R2: a first event is captured
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && !hit_one) |=> (cap_addr == $past(ev_addr)));
   // R3, R7: a repeat event sets the repeat flag, even under acknowledge
   a_r3_repeat_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && hit_one) |=> (hit_many && hit_one));
   // R3: capture is frozen while the single flag is held
   a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hit_one |=> $stable(cap_addr));
   // R6: an acknowledge with no event clears the single flag
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_one && !ev) |=> !hit_one);
endmodule

// File: rtl/ecc_cap_rdmux.sv
`timescale 1ns/1ps
module ecc_cap_rdmux
   import ecc_cap_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int SYN_W  = 8,
   parameter int REG_W  = 32,
   parameter int RA_W   = 4
) (
   input  logic [RA_W-1:0]     rd_ofs,
   input  logic [NUM_STAT-1:0] status,
   input  logic [SYN_W-1:0]    syn,
   input  logic [NUM_STAT-1:0] enable,
   input  logic [ADDR_W-1:0]   cap_a [NUM_CLS],
   input  logic [DATA_W-1:0]   cap_d [NUM_CLS],
   output logic [REG_W-1:0]    rdata
);
   localparam int WIDE = 2 * REG_W;

   logic [WIDE-1:0] pad_a [NUM_CLS];
   logic [WIDE-1:0] pad_d [NUM_CLS];
   logic            unused_oor_d;
   assign unused_oor_d = ^cap_d[CLS_OOR];

   generate
      for (genvar c = 0; c < NUM_CLS; c++) begin : g_pad
         always_comb begin
            pad_a[c]             = '0;
            pad_a[c][ADDR_W-1:0] = cap_a[c];
            pad_d[c]             = '0;
            pad_d[c][DATA_W-1:0] = cap_d[c];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (int'(rd_ofs))
         OFS_STATUS: begin
            rdata[NUM_STAT-1:0]            = status;
            rdata[SYN_LSB +: SYN_W]        = syn;
         end
         OFS_ENABLE: rdata[NUM_STAT-1:0] = enable;
         OFS_OOR_AL: rdata = pad_a[CLS_OOR][REG_W-1:0];
         OFS_OOR_AH: rdata = pad_a[CLS_OOR][WIDE-1:REG_W];
         OFS_CE_AL:  rdata = pad_a[CLS_CE][REG_W-1:0];
         OFS_CE_AH:  rdata = pad_a[CLS_CE][WIDE-1:REG_W];
         OFS_CE_DL:  rdata = pad_d[CLS_CE][REG_W-1:0];
         OFS_CE_DH:  rdata = pad_d[CLS_CE][WIDE-1:REG_W];
         OFS_UE_AL:  rdata = pad_a[CLS_UE][REG_W-1:0];
         OFS_UE_AH:  rdata = pad_a[CLS_UE][WIDE-1:REG_W];
         OFS_UE_DL:  rdata = pad_d[CLS_UE][REG_W-1:0];
         OFS_UE_DH:  rdata = pad_d[CLS_UE][WIDE-1:REG_W];
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_cap_irq.sv
`timescale 1ns/1ps
module ecc_cap_irq #(
   parameter int N       = 7,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status,
   input  logic [N-1:0] enable,
   output logic         irq
);
   logic any_live;
   assign any_live = |(status & enable);

   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= any_live;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq        = any_live;
      end
   endgenerate
endmodule

// File: rtl/ecc_err_capture.sv
`timescale 1ns/1ps
module ecc_err_capture
   import ecc_cap_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int DATA_W  = 64,
   parameter int SYN_W   = 8,
   parameter int REG_W   = 32,
   parameter int RA_W    = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oor_evt,
   input  logic              ce_evt,
   input  logic              ue_evt,
   input  logic              init_evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [DATA_W-1:0] evt_data,
   input  logic [SYN_W-1:0]  evt_syn,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 2 * REG_W) else $fatal(1, "ADDR_W out of range");
      assert (DATA_W >= 1 && DATA_W <= 2 * REG_W) else $fatal(1, "DATA_W out of range");
      assert (SYN_LSB + SYN_W <= REG_W)           else $fatal(1, "syndrome field too wide");
      assert (REG_W > SYN_LSB)                    else $fatal(1, "REG_W too narrow");
      assert ((1 << RA_W) >= NUM_OFS)             else $fatal(1, "RA_W too narrow");
   end

   logic                status_wr, enable_wr;
   logic [NUM_STAT-1:0] ack;
   logic [NUM_CLS-1:0]  ev_vec, one_v, many_v;
   logic [ADDR_W-1:0]   cap_a [NUM_CLS];
   logic [DATA_W-1:0]   cap_d [NUM_CLS];
   logic [NUM_STAT-1:0] status, en_q;
   logic                init_q;
   logic [SYN_W-1:0]    syn_q;
   logic                unused_wd;

   assign status_wr = reg_we && (int'(reg_addr) == OFS_STATUS);
   assign enable_wr = reg_we && (int'(reg_addr) == OFS_ENABLE);
   assign ack       = status_wr ? reg_wdata[NUM_STAT-1:0] : '0;
   assign unused_wd = ^reg_wdata[REG_W-1:NUM_STAT];

   assign ev_vec[CLS_OOR] = oor_evt;
   assign ev_vec[CLS_CE]  = ce_evt;
   assign ev_vec[CLS_UE]  = ue_evt;

   generate
      for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
         ecc_evt_tracker #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .CAP_DATA(c != CLS_OOR)
         ) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ev_vec[c]),
            .ack_one (ack[2*c]),
            .ack_many(ack[2*c+1]),
            .ev_addr (evt_addr),
            .ev_data (evt_data),
            .hit_one (one_v[c]),
            .hit_many(many_v[c]),
            .cap_addr(cap_a[c]),
            .cap_data(cap_d[c])
         );
         assign status[2*c]   = one_v[c];
         assign status[2*c+1] = many_v[c];
      end
   endgenerate

   assign status[ST_INIT] = init_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         syn_q  <= '0;
         en_q   <= '0;
      end else begin
         init_q <= init_evt | (init_q & ~ack[ST_INIT]);
         if (ce_evt || ue_evt) syn_q <= evt_syn;
         if (enable_wr)        en_q  <= reg_wdata[NUM_STAT-1:0];
      end
   end

   ecc_cap_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYN_W(SYN_W), .REG_W(REG_W), .RA_W(RA_W)
   ) u_rd (
      .rd_ofs(reg_addr),
      .status(status),
      .syn   (syn_q),
      .enable(en_q),
      .cap_a (cap_a),
      .cap_d (cap_d),
      .rdata (reg_rdata)
   );

   ecc_cap_irq #(.N(NUM_STAT), .REG_OUT(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .status(status),
      .enable(en_q),
      .irq   (irq)
   );

   // R4: init pulse sets the completion flag
   a_r4_init_sets: assert property (@(posedge clk) disable iff (!rst_n)
      init_evt |=> status[ST_INIT]);
   // R5: an ECC event loads its syndrome
   a_r5_syn_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt || ue_evt) |=> (syn_q == $past(evt_syn)));
   // R5: out-of-range events alone leave the syndrome
   a_r5_syn_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce_evt || ue_evt) |=> $stable(syn_q));
   // R8: no enable for two cycles means no interrupt
   a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0 && $past(en_q) == '0) |-> !irq);
   // R10: simultaneous ECC events are both flagged
   a_r10_both: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt && ue_evt) |=> (status[2*CLS_CE] && status[2*CLS_UE]));
endmodule

// File: tb/tb_ecc_err_capture.sv
`timescale 1ns/1ps
module tb_ecc_err_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        oor_evt = 0, ce_evt = 0, ue_evt = 0, init_evt = 0;
   logic [63:0] evt_addr = '0, evt_data = '0;
   logic [7:0]  evt_syn = '0;
   logic        reg_we = 0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ecc_err_capture dut (
      .clk(clk), .rst_n(rst_n), .oor_evt(oor_evt), .ce_evt(ce_evt), .ue_evt(ue_evt),
      .init_evt(init_evt), .evt_addr(evt_addr), .evt_data(evt_data), .evt_syn(evt_syn),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // scoreboard queues
   bit          kind_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];
   event        mon_ev;

   initial begin
      forever begin
         @(mon_ev);
         while (exp_q.size() > 0) begin
            bit          k;
            logic [31:0] e, act;
            string       t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = k ? {31'b0, irq} : reg_rdata;
            checks++;
            if (act !== e) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", t, act, e);
            end
         end
      end
   end

   function automatic logic [31:0] stw(input logic [6:0] bits, input logic [7:0] syn);
      return {8'h00, syn, 9'h000, bits};
   endfunction

   task automatic rd(input int a, input logic [31:0] e, input string t);
      reg_addr = 4'(a);
      kind_q.push_back(1'b0);
      exp_q.push_back(e);
      tag_q.push_back($sformatf("%s ofs=%0d", t, a));
      #1 -> mon_ev;
      #1;
   endtask

   task automatic chk_irq(input bit e, input string t);
      kind_q.push_back(1'b1);
      exp_q.push_back({31'b0, e});
      tag_q.push_back(t);
      #1 -> mon_ev;
      #1;
   endtask

   task automatic evt(input bit o, input bit c, input bit u, input bit i,
                      input logic [63:0] a, input logic [63:0] d, input logic [7:0] s,
                      input bit ackw, input logic [31:0] ackv);
      @(negedge clk);
      oor_evt = o; ce_evt = c; ue_evt = u; init_evt = i;
      evt_addr = a; evt_data = d; evt_syn = s;
      if (ackw) begin reg_we = 1; reg_addr = 4'd0; reg_wdata = ackv; end
      @(negedge clk);
      oor_evt = 0; ce_evt = 0; ue_evt = 0; init_evt = 0; reg_we = 0;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   localparam logic [63:0] A1 = 64'h0000_0001_2345_6780, D1 = 64'h0101_0101_0101_0100;
   localparam logic [63:0] A2 = 64'h0000_0002_0000_0040, D2 = 64'hDEAD_BEEF_0BAD_F00D;
   localparam logic [63:0] A3 = 64'h0000_0003_0000_1000, D3 = 64'h0101_0101_0101_010F;
   localparam logic [63:0] A4 = 64'hFFFF_0000_8000_0000;
   localparam logic [63:0] A5 = 64'h0000_0004_0000_0200, D5 = 64'hCAFE_0000_1234_5678;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      for (int k = 0; k < 12; k++) rd(k, 32'h0, "R1 reset");
      chk_irq(1'b0, "R1 irq after reset");

      // R2, R5: first correctable
      evt(0, 1, 0, 0, A1, D1, 8'h5B, 0, 0);
      rd(0, stw(7'h04, 8'h5B), "R2/R5 status first CE");
      rd(4, A1[31:0], "R2 CE addr lo");
      rd(5, A1[63:32], "R2 CE addr hi");
      rd(6, D1[31:0], "R2 CE data lo");
      rd(7, D1[63:32], "R2 CE data hi");

      // R3, R5: repeated correctable
      evt(0, 1, 0, 0, A2, D2, 8'h13, 0, 0);
      rd(0, stw(7'h0C, 8'h13), "R3/R5 status repeat CE");
      rd(4, A1[31:0], "R3 CE addr kept");
      rd(7, D1[63:32], "R3 CE data kept");

      // R2: first uncorrectable
      evt(0, 0, 1, 0, A3, D3, 8'hE9, 0, 0);
      rd(0, stw(7'h1C, 8'hE9), "R2 status first UE");
      rd(8, A3[31:0], "R2 UE addr lo");
      rd(9, A3[63:32], "R2 UE addr hi");
      rd(10, D3[31:0], "R2 UE data lo");
      rd(11, D3[63:32], "R2 UE data hi");

      // R2, R5: out-of-range, syndrome input ignored
      evt(1, 0, 0, 0, A4, D2, 8'h77, 0, 0);
      rd(0, stw(7'h1D, 8'hE9), "R5 status OOR keeps syndrome");
      rd(2, A4[31:0], "R2 OOR addr lo");
      rd(3, A4[63:32], "R2 OOR addr hi");

      // R3: repeated out-of-range
      evt(1, 0, 0, 0, A2, D2, 8'h00, 0, 0);
      rd(0, stw(7'h1F, 8'hE9), "R3 status repeat OOR");
      rd(2, A4[31:0], "R3 OOR addr kept");

      // R4: init complete
      evt(0, 0, 0, 1, '0, '0, 8'h00, 0, 0);
      rd(0, stw(7'h5F, 8'hE9), "R4 status init");

      // R8, R9: enable and interrupt
      chk_irq(1'b0, "R8 irq with enable zero");
      wr(1, 32'h0000_0040);
      chk_irq(1'b1, "R8 irq init enabled");
      rd(1, 32'h40, "R9 enable readback");
      wr(1, 32'hFFFF_FF04);
      rd(1, 32'h04, "R9 enable upper bits");
      chk_irq(1'b1, "R8 irq CE enabled");

      // R6: partial acknowledge
      wr(0, 32'h0000_000C);
      rd(0, stw(7'h53, 8'hE9), "R6 status after ack");
      rd(4, A1[31:0], "R6 CE addr after ack");
      chk_irq(1'b0, "R8 irq after ack");

      // R7: UE repeat collides with UE single ack
      evt(0, 0, 1, 0, A5, D5, 8'h2C, 1, 32'h0000_0010);
      rd(0, stw(7'h73, 8'h2C), "R7 event beats ack");
      rd(8, A3[31:0], "R7 UE addr kept");

      // R6, R9: full ack, read-only write, unmapped read
      wr(0, 32'h0000_007F);
      rd(0, stw(7'h00, 8'h2C), "R6 status all acked");
      wr(2, 32'h1234_5678);
      rd(2, A4[31:0], "R9 write to capture ignored");
      rd(15, 32'h0, "R9 unmapped offset");

      // R10, R7: CE and UE together, CE ack in same cycle while CE clear
      evt(0, 1, 1, 0, A5, D5, 8'h2A, 1, 32'h0000_0004);
      rd(0, stw(7'h14, 8'h2A), "R10/R7 status both");
      rd(4, A5[31:0], "R10 CE addr");
      rd(7, D5[63:32], "R10 CE data hi");
      rd(8, A5[31:0], "R10 UE addr");
      rd(11, D5[63:32], "R10 UE data hi");
      chk_irq(1'b1, "R8 irq CE set");
      wr(1, 32'h0);
      chk_irq(1'b0, "R8 irq disabled");

      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule